// File: doc/BRIEF.md
# Single-Word SPI Master with Register Port

This block is a serial peripheral interface master that moves one word per exchange between a host and a selected slave device. Software reaches it through a small synchronous register port (address, write enable, write data, combinational read data). It writes a chip-select index and enable, sets the clock polarity, clock phase and word size, clears the completion flag, and then writes the transmit register. That write launches a full-duplex exchange: the word leaves on MOSI most significant bit first while the same number of bits are gathered from MISO.

When the final bit has been sampled, the completion flag in the cause register becomes nonzero. Software polls this flag, reads the received word from the receive register, and writes zero to the cause register before the next exchange. The serial clock comes from an instantiated divider that runs only during an exchange. Eight active-low chip-select lines are decoded from a three-bit index and gated by one enable bit.

Top module: `spim_word_master`

## Requirements
- R1: After reset every chip-select output is high, SCLK is 0, and the control, cause and receive registers all read 0.
- R2: Registers sit at byte offsets 0x00 (control), 0x04 (configuration), 0x08 (transmit), 0x0C (receive) and 0x10 (cause). Configuration keeps only bit 5 (word size), bit 11 (polarity) and bit 12 (phase), and it reads back exactly those bits.
- R3: Control bits 4:2 hold a chip-select index from 0 to 7 and control bit 0 is the select enable. Outputs are active low: with the enable at 1 only the indexed line is low, and with the enable at 0 all lines are high.
- R4: A write to the transmit register while idle starts an exchange, and control bit 1 reads 1 while the exchange runs.
- R5: With configuration bit 5 at 0 the exchange moves 8 bits: transmit bits 7:0 leave MSB first, the received byte lands in receive bits 7:0, and receive bits 31:8 read 0.
- R6: With configuration bit 5 at 1 the exchange moves 16 bits: transmit bits 15:0 leave MSB first, and the received word lands in receive bits 15:0.
- R7: Polarity and phase select the SPI mode. With phase 0 MISO is sampled on the leading SCLK edge and MOSI changes on the trailing edge. With phase 1 MOSI changes on the leading edge and MISO is sampled on the trailing edge. A leading edge is one that moves SCLK away from its rest level.
- R8: The cause register reads 0 during an exchange and reads 1 (bit 0) once the last bit has been sampled. Writing 0 clears it. A nonzero write leaves it unchanged.
- R9: A transmit-register write made while an exchange is in progress is ignored: the running exchange keeps its data and its length, and no second exchange follows it.
- R10: SCLK rests at the polarity level whenever no exchange is running. Each exchange produces exactly two SCLK edges per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W (5) | Register byte address |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | DATA_W (32) | Register write data |
| bus_rdata | output | DATA_W (32) | Register read data for bus_addr, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |
| cs_n | output | NCS (8) | Active-low chip selects |

## Verification
A wrong bit or edge counter in the shift engine shows on the ports within one exchange. The received word comes back shifted or truncated, the slave model captures a misaligned MOSI word, and the SCLK edge count differs from twice the word size. A stuck busy state or a mis-set cause flag shows on the next poll of the control or cause register. An SCLK that is not at rest shows as soon as the polarity is written. A decode error on chip select shows on cs_n one cycle after the control write. Any restart caused by a transmit write during an exchange shows in the same exchange, as extra SCLK edges or as a corrupted received word.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int WIDE_BITS   = 16;
  localparam int NARROW_BITS = 8;

  // register byte offsets
  localparam int OFS_CTRL  = 'h00;
  localparam int OFS_CFG   = 'h04;
  localparam int OFS_TX    = 'h08;
  localparam int OFS_RX    = 'h0C;
  localparam int OFS_CAUSE = 'h10;

  // field positions
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_BUSY_BIT = 1;
  localparam int CTRL_IDX_LSB  = 2;
  localparam int CFG_WIDE_BIT  = 5;
  localparam int CFG_CPOL_BIT  = 11;
  localparam int CFG_CPHA_BIT  = 12;

  typedef struct packed {
    logic cpha;
    logic cpol;
    logic wide;
  } spim_mode_t;

  function automatic int unsigned word_bits(input logic wide);
    return wide ? WIDE_BITS : NARROW_BITS;
  endfunction

  // place the outgoing word so that its MSB sits at the top of the shifter
  function automatic logic [WIDE_BITS-1:0] align_tx(input logic wide,
                                                    input logic [WIDE_BITS-1:0] d);
    return wide ? d : {d[NARROW_BITS-1:0], {(WIDE_BITS-NARROW_BITS){1'b0}}};
  endfunction

  // keep only the bits that were shifted in during this exchange
  function automatic logic [WIDE_BITS-1:0] trim_rx(input logic wide,
                                                   input logic [WIDE_BITS-1:0] d);
    return wide ? d : {{(WIDE_BITS-NARROW_BITS){1'b0}}, d[NARROW_BITS-1:0]};
  endfunction

  // edges are numbered from 0; even numbers are leading edges
  function automatic logic is_sample_edge(input logic cpha, input logic edge_odd);
    return edge_odd == cpha;
  endfunction

endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = $clog2(HALF_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int EW = $clog2(2 * WIDE_BITS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [WIDE_BITS-1:0] tx_word,
  input  spim_mode_t           mode,
  input  logic                 tick,
  input  logic                 miso,
  output logic                 busy,
  output logic                 done,
  output logic                 phase,
  output logic                 mosi,
  output logic [WIDE_BITS-1:0] rx_word,
  output logic [EW-1:0]        edge_idx
);
  logic [WIDE_BITS-1:0] sh_tx_q, sh_rx_q;
  logic [EW-1:0]        edge_q;
  logic                 busy_q, done_q, phase_q;
  logic [EW-1:0]        last_edge;
  logic                 sample_now, shift_now;

  assign last_edge  = EW'(2 * word_bits(mode.wide) - 1);
  assign sample_now = is_sample_edge(mode.cpha, edge_q[0]);
  // with phase 1 the first bit is already on MOSI before the first leading edge
  assign shift_now  = !sample_now && !(mode.cpha && (edge_q == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      phase_q <= 1'b0;
      edge_q  <= '0;
      sh_tx_q <= '0;
      sh_rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !busy_q) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        edge_q  <= '0;
        sh_tx_q <= tx_word;
        sh_rx_q <= '0;
      end else if (busy_q && tick) begin
        phase_q <= ~phase_q;
        if (sample_now) sh_rx_q <= {sh_rx_q[WIDE_BITS-2:0], miso};
        if (shift_now)  sh_tx_q <= {sh_tx_q[WIDE_BITS-2:0], 1'b0};
        if (edge_q == last_edge) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          edge_q <= edge_q + 1'b1;
        end
      end
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign phase    = phase_q;
  assign mosi     = sh_tx_q[WIDE_BITS-1];
  assign rx_word  = trim_rx(mode.wide, sh_rx_q);
  assign edge_idx = edge_q;
endmodule

// File: rtl/spim_regs.sv
module spim_regs
  import spim_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int NCS    = 8,
  localparam int IDXW  = $clog2(NCS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 busy,
  input  logic                 done,
  input  logic [WIDE_BITS-1:0] rx_word,
  output logic                 start,
  output logic                 tx_wr,
  output logic [WIDE_BITS-1:0] tx_word,
  output spim_mode_t           mode,
  output logic                 cs_en,
  output logic [IDXW-1:0]      cs_idx,
  output logic                 cause_flag
);
  logic hit_ctrl, hit_cfg, hit_tx, hit_rx, hit_cause;

  assign hit_ctrl  = bus_addr == ADDR_W'(OFS_CTRL);
  assign hit_cfg   = bus_addr == ADDR_W'(OFS_CFG);
  assign hit_tx    = bus_addr == ADDR_W'(OFS_TX);
  assign hit_rx    = bus_addr == ADDR_W'(OFS_RX);
  assign hit_cause = bus_addr == ADDR_W'(OFS_CAUSE);

  spim_mode_t           mode_q;
  logic                 en_q, cause_q;
  logic [IDXW-1:0]      idx_q;
  logic [WIDE_BITS-1:0] rx_q, txlast_q;

  assign tx_wr   = bus_we && hit_tx;
  assign start   = tx_wr && !busy;
  assign tx_word = align_tx(mode_q.wide, bus_wdata[WIDE_BITS-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      en_q     <= 1'b0;
      idx_q    <= '0;
      cause_q  <= 1'b0;
      rx_q     <= '0;
      txlast_q <= '0;
    end else begin
      if (bus_we && hit_ctrl) begin
        en_q  <= bus_wdata[CTRL_EN_BIT];
        idx_q <= bus_wdata[CTRL_IDX_LSB +: IDXW];
      end
      if (bus_we && hit_cfg) begin
        mode_q.cpha <= bus_wdata[CFG_CPHA_BIT];
        mode_q.cpol <= bus_wdata[CFG_CPOL_BIT];
        mode_q.wide <= bus_wdata[CFG_WIDE_BIT];
      end
      if (start) txlast_q <= bus_wdata[WIDE_BITS-1:0];
      if (done) begin
        cause_q <= 1'b1;
        rx_q    <= rx_word;
      end else if (bus_we && hit_cause && (bus_wdata == '0)) begin
        cause_q <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl) begin
      bus_rdata[CTRL_EN_BIT]             = en_q;
      bus_rdata[CTRL_BUSY_BIT]           = busy;
      bus_rdata[CTRL_IDX_LSB +: IDXW]    = idx_q;
    end else if (hit_cfg) begin
      bus_rdata[CFG_CPHA_BIT]            = mode_q.cpha;
      bus_rdata[CFG_CPOL_BIT]            = mode_q.cpol;
      bus_rdata[CFG_WIDE_BIT]            = mode_q.wide;
    end else if (hit_tx) begin
      bus_rdata[WIDE_BITS-1:0]           = txlast_q;
    end else if (hit_rx) begin
      bus_rdata[WIDE_BITS-1:0]           = rx_q;
    end else if (hit_cause) begin
      bus_rdata[0]                       = cause_q;
    end
  end

  assign mode       = mode_q;
  assign cs_en      = en_q;
  assign cs_idx     = idx_q;
  assign cause_flag = cause_q;
endmodule

// File: rtl/spim_word_master.sv
module spim_word_master
  import spim_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int NCS      = 8,
  parameter int HALF_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_n
);
  localparam int IDXW   = $clog2(NCS);
  localparam int EDGE_W = $clog2(2 * WIDE_BITS);

  // named internal events, also used by the bound checker
  logic                 start_w, tx_wr_w, busy_w, done_w, tick_w, phase_w;
  logic                 cs_en_w, cause_w, cpol_w;
  logic [IDXW-1:0]      cs_idx_w;
  logic [WIDE_BITS-1:0] tx_word_w, rx_word_w;
  logic [EDGE_W-1:0]    edge_idx_w;
  spim_mode_t           mode_w;

  spim_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCS(NCS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .busy       (busy_w),
    .done       (done_w),
    .rx_word    (rx_word_w),
    .start      (start_w),
    .tx_wr      (tx_wr_w),
    .tx_word    (tx_word_w),
    .mode       (mode_w),
    .cs_en      (cs_en_w),
    .cs_idx     (cs_idx_w),
    .cause_flag (cause_w)
  );

  spim_clkdiv #(.HALF_CYC(HALF_CYC)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (busy_w),
    .tick  (tick_w)
  );

  spim_shifter #(.EW(EDGE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start_w),
    .tx_word  (tx_word_w),
    .mode     (mode_w),
    .tick     (tick_w),
    .miso     (miso),
    .busy     (busy_w),
    .done     (done_w),
    .phase    (phase_w),
    .mosi     (mosi),
    .rx_word  (rx_word_w),
    .edge_idx (edge_idx_w)
  );

  assign cpol_w = mode_w.cpol;
  assign sclk   = phase_w ^ cpol_w;

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_n[i] = !(cs_en_w && (cs_idx_w == IDXW'(i)));
  end
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int NCS = 8,
  parameter int EW  = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] cs_n,
  input logic           sclk,
  input logic           cpol,
  input logic           busy,
  input logic           done,
  input logic           tx_wr,
  input logic           cause_flag,
  input logic           cs_en,
  input logic [EW-1:0]  edge_idx
);
  assert_cs_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  assert_cs_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_en |-> (&cs_n));

  assert_start_by_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_wr));

  assert_done_sets_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cause_flag);

  assert_done_is_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tx_wr) |=> (edge_idx >= $past(edge_idx)));

  assert_sclk_rest_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sclk == cpol));
endmodule

bind spim_word_master spim_checker #(.NCS(NCS), .EW($clog2(2 * spim_pkg::WIDE_BITS))) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .sclk       (sclk),
  .cpol       (cpol_w),
  .busy       (busy_w),
  .done       (done_w),
  .tx_wr      (tx_wr_w),
  .cause_flag (cause_w),
  .cs_en      (cs_en_w),
  .edge_idx   (edge_idx_w)
);

// File: tb/tb_spim_word_master.sv
`timescale 1ns/1ps
module tb_spim_word_master;
  localparam int A_CTRL = 'h00, A_CFG = 'h04, A_TX = 'h08, A_RX = 'h0C, A_CAUSE = 'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sclk, mosi;
  logic        miso = 1'b0;
  logic [7:0]  cs_n;

  always #2.5 clk = ~clk;

  spim_word_master dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_n(cs_n)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 5'(a); bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = 5'(a);
    #1 v = bus_rdata;
  endtask

  // behavioural slave
  logic        sl_armed = 1'b0, sl_cpol = 1'b0, sl_cpha = 1'b0;
  logic [15:0] sl_out = '0, sl_in = '0;
  int          sl_edges = 0;

  always @(sclk) begin
    if (sl_armed) begin
      sl_edges++;
      if (sclk != sl_cpol) begin
        if (!sl_cpha) sl_in = {sl_in[14:0], mosi};
        else if (sl_edges > 1) begin sl_out = sl_out << 1; miso = sl_out[15]; end
      end else begin
        if (!sl_cpha) begin sl_out = sl_out << 1; miso = sl_out[15]; end
        else sl_in = {sl_in[14:0], mosi};
      end
    end
  end

  // scoreboard
  typedef struct {
    logic [31:0] rx;
    logic [15:0] mo;
    int          edges;
    string       tag;
  } item_t;

  item_t       exp_q[$];
  logic [31:0] obs_rx;
  logic [15:0] obs_mo;
  int          obs_edges;
  event        obs_ev;

  initial begin
    forever begin
      @(obs_ev);
      if (exp_q.size() == 0) begin
        chk("R4", "unexpected exchange", 32'h1, 32'h0);
      end else begin
        item_t e;
        e = exp_q.pop_front();
        chk("R5/R6", {e.tag, " rx word"}, obs_rx, e.rx);
        chk("R7", {e.tag, " mosi word seen by slave"}, {16'h0, obs_mo}, {16'h0, e.mo});
        chk("R10", {e.tag, " sclk edge count"}, obs_edges, e.edges);
      end
    end
  end

  task automatic do_xfer(input int cs, input bit wide, input bit cpol, input bit cpha,
                         input logic [15:0] txw, input logic [15:0] slw,
                         input bit poke, input string tag);
    logic [31:0] v;
    int          nb;
    logic [15:0] msk;
    item_t       e;
    nb  = wide ? 16 : 8;
    msk = wide ? 16'hFFFF : 16'h00FF;
    bus_write(A_CTRL, 32'((cs << 2) | 1));
    chk("R3", {tag, " cs_n selected"}, {24'h0, cs_n}, {24'h0, ~(8'h01 << cs)});
    bus_write(A_CFG, 32'((int'(cpha) << 12) | (int'(cpol) << 11) | (int'(wide) << 5)));
    chk("R10", {tag, " sclk idle level"}, {31'h0, sclk}, {31'h0, cpol});
    bus_write(A_CAUSE, 32'h0);
    sl_cpol = cpol; sl_cpha = cpha; sl_edges = 0; sl_in = '0;
    sl_out = wide ? slw : {slw[7:0], 8'h00};
    miso = sl_out[15];
    sl_armed = 1'b1;
    e.rx = {16'h0, slw & msk}; e.mo = txw & msk; e.edges = 2 * nb; e.tag = tag;
    exp_q.push_back(e);
    bus_write(A_TX, {16'hABCD, txw});
    bus_read(A_CTRL, v);
    chk("R4", {tag, " busy bit during exchange"}, {31'h0, v[1]}, 32'h1);
    bus_read(A_CAUSE, v);
    chk("R8", {tag, " cause clear during exchange"}, v, 32'h0);
    if (poke) bus_write(A_TX, {16'h0, ~txw});
    for (int k = 0; k < 4000; k++) begin
      bus_read(A_CAUSE, v);
      if (v != 0) break;
    end
    chk("R8", {tag, " cause set at end"}, v, 32'h1);
    chk("R10", {tag, " sclk back at rest"}, {31'h0, sclk}, {31'h0, cpol});
    bus_read(A_RX, v);
    obs_rx = v; obs_mo = sl_in & msk; obs_edges = sl_edges;
    ->obs_ev;
    sl_armed = 1'b0;
    bus_write(A_CAUSE, 32'h5);
    bus_read(A_CAUSE, v);
    chk("R8", {tag, " nonzero write keeps cause"}, v, 32'h1);
    bus_write(A_CAUSE, 32'h0);
    bus_read(A_CAUSE, v);
    chk("R8", {tag, " zero write clears cause"}, v, 32'h0);
    if (poke) begin
      repeat (200) @(negedge clk);
      bus_read(A_CTRL, v);
      chk("R9", {tag, " no second exchange (busy)"}, {31'h0, v[1]}, 32'h0);
      bus_read(A_CAUSE, v);
      chk("R9", {tag, " no second exchange (cause)"}, v, 32'h0);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "cs_n after reset", {24'h0, cs_n}, 32'hFF);
    chk("R1", "sclk after reset", {31'h0, sclk}, 32'h0);
    bus_read(A_CTRL, v);  chk("R1", "ctrl in reset", v, 32'h0);
    rst_n = 1'b1;
    bus_read(A_CTRL, v);  chk("R1", "ctrl after reset", v, 32'h0);
    bus_read(A_CAUSE, v); chk("R1", "cause after reset", v, 32'h0);
    bus_read(A_RX, v);    chk("R1", "rx after reset", v, 32'h0);
    // R2 register map and readback
    bus_write(A_CFG, 32'hFFFF_FFFF);
    bus_read(A_CFG, v);   chk("R2", "cfg keeps bits 12,11,5", v, 32'h0000_1820);
    bus_write(A_CFG, 32'h0);
    bus_write(A_CTRL, 32'h1D);
    bus_read(A_CTRL, v);  chk("R2", "ctrl readback", v, 32'h1D);
    chk("R3", "index 7 enabled", {24'h0, cs_n}, 32'h7F);
    bus_write(A_CTRL, 32'h14);
    chk("R3", "enable 0 releases all", {24'h0, cs_n}, 32'hFF);
    // exchanges in all four modes, both sizes
    do_xfer(0, 1'b0, 1'b0, 1'b0, 16'h00A5, 16'h003C, 1'b0, "R5 m0 8b");
    do_xfer(7, 1'b0, 1'b1, 1'b1, 16'h0081, 16'h007E, 1'b0, "R5 m3 8b");
    do_xfer(3, 1'b1, 1'b0, 1'b1, 16'hBEEF, 16'h1234, 1'b0, "R6 m1 16b");
    do_xfer(5, 1'b1, 1'b1, 1'b0, 16'h8001, 16'hF00F, 1'b1, "R9 m2 16b busy write");
    do_xfer(2, 1'b0, 1'b0, 1'b1, 16'h005A, 16'h00C3, 1'b1, "R9 m1 8b busy write");
    do_xfer(6, 1'b1, 1'b1, 1'b1, 16'h0F0F, 16'hA5A5, 1'b0, "R7 m3 16b");
    bus_read(A_TX, v);    chk("R2", "tx readback of last started word", v, 32'h0000_0F0F);
    bus_write(A_CTRL, 32'h18);
    chk("R3", "deselect after exchanges", {24'h0, cs_n}, 32'hFF);
    #1;
    chk("R4", "scoreboard drained", exp_q.size(), 32'h0);
    finish_run();
  end
endmodule